// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This combinational unit sits in the execute stage of a small processor datapath. It moves the bits of one operand by a count taken from an instruction field or a register. The operation code picks one of eight operations: logical or arithmetic shift left, logical or arithmetic shift right, plain rotate left or right, and rotate left or right through the carry flag. The result and the outgoing carry are valid in the same cycle as the inputs.

A size select sets the active operand width to 8, 16 or 32 bits. Only the low bits of the operand at that width take part. The result is zero-extended above the active width. The carry-out is the last bit that moved past an end of the operand. For the through-carry rotates, the incoming carry acts as one extra bit of the ring.

Top module: `srcu_top`

## Requirements
- R1: Only the low five bits of `count` are used, so the effective count n is `count` modulo 32. Any higher count bits have no effect.
- R2: When n is 0, every operation returns the operand at the active width unchanged, and `carry_out` equals `carry_in`.
- R3: `size_sel` 2'b00 selects 8 bits, 2'b01 selects 16 bits, and 2'b10 or 2'b11 select 32 bits (W). Operand bits at or above W are ignored, and result bits at or above W are zero.
- R4: `op_sel` 3'd0 and 3'd1 both shift left and behave identically. Zeros enter at bit 0. `carry_out` is operand bit W-n when n ≤ W and 0 when n > W. The result is all zeros when n ≥ W.
- R5: `op_sel` 3'd2 is a logical shift right. Zeros enter at bit W-1. `carry_out` is operand bit n-1 when n ≤ W and 0 when n > W.
- R6: `op_sel` 3'd3 is an arithmetic shift right. Copies of the original bit W-1 enter at the top. `carry_out` is operand bit n-1 when n ≤ W and the original bit W-1 when n > W. For example, 8-bit 0xDE shifted by 2 gives 0xF7 with carry 1.
- R7: `op_sel` 3'd4 rotates left and 3'd5 rotates right by n modulo W, with a nonzero n. `carry_out` is result bit 0 for left and result bit W-1 for right. For example, 8-bit 0x3E rotated right by 2 gives 0x8F with carry 1.
- R8: `op_sel` 3'd6 rotates left through carry and 3'd7 rotates right through carry. The ring is W+1 bits: `carry_in` above the operand. The ring turns by n modulo (W+1), and the new carry is the ring's top bit. With carry in 1, 8-bit 0x33 gives 0xCE with carry 0 to the left and 0xCC with carry 1 to the right.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand | input | DATA_W (32) | Value to shift or rotate |
| count | input | CNT_IN_W (8) | Requested count; only the low five bits are used |
| op_sel | input | 3 | Operation code |
| size_sel | input | 2 | Active operand width select |
| carry_in | input | 1 | Incoming carry flag |
| result | output | DATA_W (32) | Result, zero above the active width |
| carry_out | output | 1 | Outgoing carry flag |

## Verification
The embedded assertions are immediate checks on a purely combinational path. They assume every input is driven to a known two-state value whenever it is evaluated. The bench therefore drives all inputs to zero before time advances, and changes them only just after a rising edge. The assertions also assume that `size_sel` 2'b11 is a legal alias of the 32-bit width. The sweeps include that code deliberately, together with count values whose upper bits are set and operands with data above the active width.

// File: rtl/srcu_pkg.sv
package srcu_pkg;
   typedef enum logic [2:0] {
      OP_LSL   = 3'd0,
      OP_ASL   = 3'd1,
      OP_LSR   = 3'd2,
      OP_ASR   = 3'd3,
      OP_ROTL  = 3'd4,
      OP_ROTR  = 3'd5,
      OP_CROTL = 3'd6,
      OP_CROTR = 3'd7
   } srcu_op_e;

   localparam int unsigned NUM_SIZES = 3;
endpackage

// File: rtl/srcu_shifter.sv
module srcu_shifter #(
   parameter int unsigned W    = 8,
   parameter int unsigned SH_W = 5
) (
   input  logic [W-1:0]    a,
   input  logic [SH_W-1:0] n,
   output logic [W-1:0]    left_res,
   output logic            left_c,
   output logic [W-1:0]    rlog_res,
   output logic            rlog_c,
   output logic [W-1:0]    rari_res,
   output logic            rari_c
);
   logic [W:0]        lx;
   logic [W:0]        rx;
   logic signed [W:0] sx;
   logic signed [W:0] rxa;

   always_comb begin
      lx  = {1'b0, a} << n;
      rx  = {a, 1'b0} >> n;
      sx  = {a, 1'b0};
      rxa = sx >>> n;
   end

   assign left_res = lx[W-1:0];
   assign left_c   = lx[W];
   assign rlog_res = rx[W:1];
   assign rlog_c   = rx[0];
   assign rari_res = rxa[W:1];
   assign rari_c   = rxa[0];

   always_comb begin
      if (n != '0 && a[W-1])
         assert_asr_fill_R6: assert (rari_res[W-1]) else $error("sign fill lost");
      if (32'(n) >= W)
         assert_lsl_clear_R4: assert (left_res == '0 && rlog_res == '0) else $error("over-shift not clear");
   end
endmodule

// File: rtl/srcu_rotator.sv
module srcu_rotator #(
   parameter int unsigned W    = 8,
   parameter int unsigned SH_W = 5
) (
   input  logic [W-1:0]    a,
   input  logic [SH_W-1:0] n,
   input  logic            cin,
   output logic [W-1:0]    rl_res,
   output logic            rl_c,
   output logic [W-1:0]    rr_res,
   output logic            rr_c,
   output logic [W-1:0]    cl_res,
   output logic            cl_c,
   output logic [W-1:0]    cr_res,
   output logic            cr_c
);
   localparam int unsigned RW = W + 1;

   logic [SH_W-1:0] k;
   logic [SH_W-1:0] kc;
   logic [RW-1:0]   ring;
   logic [RW-1:0]   ring_l;
   logic [RW-1:0]   ring_r;

   always_comb begin
      k      = SH_W'(32'(n) % W);
      kc     = SH_W'(32'(n) % RW);
      rl_res = (a << k) | (a >> (W - 32'(k)));
      rr_res = (a >> k) | (a << (W - 32'(k)));
      rl_c   = (k == '0) ? a[0]   : a[W - 32'(k)];
      rr_c   = (k == '0) ? a[W-1] : a[32'(k) - 1];
      ring   = {cin, a};
      ring_l = (ring << kc) | (ring >> (RW - 32'(kc)));
      ring_r = (ring >> kc) | (ring << (RW - 32'(kc)));
   end

   assign cl_c   = ring_l[W];
   assign cl_res = ring_l[W-1:0];
   assign cr_c   = ring_r[W];
   assign cr_res = ring_r[W-1:0];

   always_comb begin
      assert_rot_pop_R7: assert ($countones(rl_res) == $countones(a)
                                 && $countones(rr_res) == $countones(a))
         else $error("rotate changed bit count");
      assert_rot_carry_R7: assert (rl_c == rl_res[0] && rr_c == rr_res[W-1])
         else $error("rotate carry mismatch");
      assert_ring_pop_R8: assert ($countones({cl_c, cl_res}) == $countones(ring)
                                  && $countones({cr_c, cr_res}) == $countones(ring))
         else $error("carry ring changed bit count");
   end
endmodule

// File: rtl/srcu_lane.sv
module srcu_lane
   import srcu_pkg::*;
#(
   parameter int unsigned W    = 8,
   parameter int unsigned SH_W = 5
) (
   input  logic [W-1:0]    a,
   input  logic [SH_W-1:0] n,
   input  srcu_op_e        op,
   input  logic            cin,
   output logic [W-1:0]    res,
   output logic            cout
);
   logic [W-1:0] l_res, rl_res, ra_res, ol_res, or_res, cl_res, cr_res;
   logic         l_c, rl_c, ra_c, ol_c, or_c, cl_c, cr_c;

   srcu_shifter #(.W(W), .SH_W(SH_W)) u_shift (
      .a(a), .n(n),
      .left_res(l_res), .left_c(l_c),
      .rlog_res(rl_res), .rlog_c(rl_c),
      .rari_res(ra_res), .rari_c(ra_c)
   );

   srcu_rotator #(.W(W), .SH_W(SH_W)) u_rot (
      .a(a), .n(n), .cin(cin),
      .rl_res(ol_res), .rl_c(ol_c),
      .rr_res(or_res), .rr_c(or_c),
      .cl_res(cl_res), .cl_c(cl_c),
      .cr_res(cr_res), .cr_c(cr_c)
   );

   always_comb begin
      res  = a;
      cout = cin;
      if (n != '0) begin
         case (op)
            OP_LSL, OP_ASL: begin res = l_res;  cout = l_c;  end
            OP_LSR:         begin res = rl_res; cout = rl_c; end
            OP_ASR:         begin res = ra_res; cout = ra_c; end
            OP_ROTL:        begin res = ol_res; cout = ol_c; end
            OP_ROTR:        begin res = or_res; cout = or_c; end
            OP_CROTL:       begin res = cl_res; cout = cl_c; end
            default:        begin res = cr_res; cout = cr_c; end
         endcase
      end
   end
endmodule

// File: rtl/srcu_top.sv
module srcu_top
   import srcu_pkg::*;
#(
   parameter int unsigned BASE_W   = 8,
   parameter int unsigned CNT_IN_W = 8
) (
   input  logic [(BASE_W << (srcu_pkg::NUM_SIZES-1))-1:0] operand,
   input  logic [CNT_IN_W-1:0]                             count,
   input  logic [2:0]                                      op_sel,
   input  logic [1:0]                                      size_sel,
   input  logic                                            carry_in,
   output logic [(BASE_W << (srcu_pkg::NUM_SIZES-1))-1:0] result,
   output logic                                            carry_out
);
   localparam int unsigned DATA_W = BASE_W << (NUM_SIZES - 1);
   localparam int unsigned SH_W   = $clog2(DATA_W);

   if ((BASE_W & (BASE_W - 1)) != 0 || BASE_W < 2) begin : g_bad_base
      $error("BASE_W must be a power of two of at least 2");
   end
   if (CNT_IN_W < SH_W) begin : g_bad_cnt
      $error("CNT_IN_W must hold at least the masked count");
   end

   logic [SH_W-1:0]   n;
   logic              unused_cnt_hi;
   logic [DATA_W-1:0] lane_res [NUM_SIZES];
   logic              lane_c   [NUM_SIZES];
   logic [1:0]        idx;

   assign n = count[SH_W-1:0];
   if (CNT_IN_W > SH_W) begin : g_cnt_hi
      assign unused_cnt_hi = ^count[CNT_IN_W-1:SH_W];
   end else begin : g_cnt_exact
      assign unused_cnt_hi = 1'b0;
   end

   for (genvar i = 0; i < NUM_SIZES; i++) begin : g_lane
      localparam int unsigned LW = BASE_W << i;
      logic [LW-1:0] lres;
      srcu_lane #(.W(LW), .SH_W(SH_W)) u_lane (
         .a(operand[LW-1:0]), .n(n), .op(srcu_op_e'(op_sel)), .cin(carry_in),
         .res(lres), .cout(lane_c[i])
      );
      assign lane_res[i] = DATA_W'(lres);
   end

   always_comb begin
      idx = (size_sel[1]) ? 2'd2 : {1'b0, size_sel[0]};
      result    = lane_res[idx];
      carry_out = lane_c[idx];
   end

   logic [DATA_W-1:0] low_mask;
   always_comb begin
      low_mask = (idx == 2'd2) ? '1 : ((DATA_W'(1) << (BASE_W << idx)) - DATA_W'(1));
      assert_upper_zero_R3: assert ((result & ~low_mask) == '0)
         else $error("bits above active width set");
      if (n == '0)
         assert_zero_pass_R2: assert (carry_out == carry_in
                                      && ((result ^ operand) & low_mask) == '0)
            else $error("zero count altered data or carry");
   end
endmodule

// File: tb/srcu_top_test.sv
module srcu_top_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] operand = '0;
   logic [7:0]  count = '0;
   logic [2:0]  op_sel = '0;
   logic [1:0]  size_sel = '0;
   logic        carry_in = 1'b0;
   logic [31:0] result;
   logic        carry_out;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   srcu_top uut (
      .operand(operand), .count(count), .op_sel(op_sel), .size_sel(size_sel),
      .carry_in(carry_in), .result(result), .carry_out(carry_out)
   );

   // Reference: moves the operand one bit position per step.
   function automatic logic [32:0] model(input logic [2:0] op, input logic [1:0] sz,
                                         input logic [31:0] a, input logic [7:0] cnt,
                                         input logic ci);
      int w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
      logic [31:0] m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
      logic [31:0] v = a & m;
      logic        c = ci;
      logic        t;
      int          steps = int'(cnt) % 32;
      if (op == 3'd6 || op == 3'd7) steps = steps % (w + 1);
      if (int'(cnt) % 32 == 0) return {ci, v};
      for (int s = 0; s < steps; s++) begin
         case (op)
            3'd0, 3'd1: begin c = v[w-1]; v = (v << 1) & m; end
            3'd2:       begin c = v[0]; v = v >> 1; end
            3'd3:       begin c = v[0]; v = (v >> 1) | ({31'd0, v[w-1]} << (w-1)); end
            3'd4:       begin c = v[w-1]; v = ((v << 1) | {31'd0, c}) & m; end
            3'd5:       begin c = v[0]; v = (v >> 1) | ({31'd0, c} << (w-1)); end
            3'd6:       begin t = v[w-1]; v = ((v << 1) | {31'd0, c}) & m; c = t; end
            default:    begin t = v[0]; v = (v >> 1) | ({31'd0, c} << (w-1)); c = t; end
         endcase
      end
      return {c, v};
   endfunction

   function automatic string tag_of(input logic [2:0] op, input logic [7:0] cnt);
      if (cnt[4:0] == 5'd0) return "R2";
      case (op)
         3'd0, 3'd1: return "R4";
         3'd2:       return "R5";
         3'd3:       return "R6";
         3'd4, 3'd5: return "R7";
         default:    return "R8";
      endcase
   endfunction

   task automatic apply(input logic [2:0] op, input logic [1:0] sz, input logic [31:0] a,
                        input logic [7:0] cnt, input logic ci, input logic [32:0] exp,
                        input string tag);
      @(posedge clk);
      op_sel = op; size_sel = sz; operand = a; count = cnt; carry_in = ci;
      @(negedge clk);
      checks++;
      if ({carry_out, result} !== exp) begin
         errors++;
         $display("FAIL %s op=%0d size=%0d a=%h cnt=%0d cin=%0d: got c=%0d r=%h, expected c=%0d r=%h",
                  tag, op, sz, a, cnt, ci, carry_out, result, exp[32], exp[31:0]);
      end
   endtask

   task automatic sweep(input logic [1:0] sz, input int npat);
      for (int p = 0; p < npat; p++) begin
         logic [31:0] a = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h8000_8080 :
                          32'(32'h9E37_79B9 * (p + 1) + 32'h0123_4567 * p);
         for (int op = 0; op < 8; op++)
            for (int c = 0; c < 32; c++)
               for (int ci = 0; ci < 2; ci++) begin
                  // R1: upper count bits carry junk that must be ignored
                  logic [7:0] cnt = 8'(c + 32 * (p % 8));
                  apply(3'(op), sz, a, cnt, ci[0],
                        model(3'(op), sz, a, cnt, ci[0]), tag_of(3'(op), cnt));
               end
      end
   endtask

   initial begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      checks++;
      if ({carry_out, result} !== 33'd0) begin
         errors++;
         $display("FAIL R2 idle state: got c=%0d r=%h, expected c=0 r=0", carry_out, result);
      end
      rst = 1'b0;
      apply(3'd0, 2'd0, 32'hABCD_EF33, 8'd2,   1'b0, {1'b0, 32'hCC}, "R4");
      apply(3'd1, 2'd0, 32'hABCD_EF33, 8'd2,   1'b0, {1'b0, 32'hCC}, "R4");
      apply(3'd0, 2'd0, 32'h0000_0033, 8'h22,  1'b1, {1'b0, 32'hCC}, "R1");
      apply(3'd3, 2'd0, 32'h1234_56DE, 8'd2,   1'b0, {1'b1, 32'hF7}, "R6");
      apply(3'd3, 2'd0, 32'h0000_0080, 8'd12,  1'b0, {1'b1, 32'hFF}, "R6");
      apply(3'd2, 2'd0, 32'h0000_00FF, 8'd9,   1'b1, {1'b0, 32'h00}, "R5");
      apply(3'd4, 2'd0, 32'h0000_0033, 8'd2,   1'b1, {1'b0, 32'hCC}, "R7");
      apply(3'd5, 2'd0, 32'h0000_003E, 8'd2,   1'b0, {1'b1, 32'h8F}, "R7");
      apply(3'd6, 2'd0, 32'h0000_0033, 8'd2,   1'b1, {1'b0, 32'hCE}, "R8");
      apply(3'd7, 2'd0, 32'h0000_0033, 8'd2,   1'b1, {1'b1, 32'hCC}, "R8");
      apply(3'd6, 2'd0, 32'h0000_0033, 8'd9,   1'b1, {1'b1, 32'h33}, "R8");
      apply(3'd0, 2'd1, 32'hFFFF_8001, 8'd16,  1'b0, {1'b1, 32'h0},  "R3");
      apply(3'd5, 2'd3, 32'h0000_0001, 8'd1,   1'b0, {1'b1, 32'h8000_0000}, "R3");
      apply(3'd2, 2'd2, 32'hDEAD_BEEF, 8'd0,   1'b1, {1'b1, 32'hDEAD_BEEF}, "R2");
      sweep(2'd0, 12);
      sweep(2'd1, 8);
      sweep(2'd2, 8);
      sweep(2'd3, 4);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got run still active, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule